// File: doc/BRIEF.md
# Serial Word-Organised EEPROM Slave

This block is the device side of a three-wire serial memory holding 1024 words of 16 bits. A host raises chip select, clocks instruction bits in on the serial clock and reads replies from a data-out pin. The pin carries an enable that stands in for high impedance. Everything runs on one system clock. The serial clock is sampled on that clock and its rising edges are found by edge detection.

An instruction has three parts: a start marker, a two-bit opcode and a ten-bit word address. The block can read words one after another, with the address rolling over at the end of the array. It can write a single word. A write-enable latch is set and cleared by two control instructions. A write is carried out by a self-timed programming sequencer whose duration is a parameter counted in system clock cycles. While chip select is high, data-out reports busy or ready until the next instruction starts.

Top module: `sereep_slave`

## Requirements
- R1: After reset the write-enable latch is clear and data-out is not driven. A WRITE issued before any enable instruction starts no programming: raising chip select afterwards leaves data-out undriven.
- R2: The start marker is a sampled 0 followed by a sampled 1, and any number of extra leading 0 bits is accepted. After it come two opcode bits (10 = READ, 01 = WRITE, 00 = control) and ten address bits, all MSB first.
- R3: On the serial clock rise that samples the last address bit of a READ, data-out drives a 0 placeholder bit. The next 16 rises present the addressed word MSB first.
- R4: When the serial clock keeps running after a word has been read, the next higher address follows at once, with no placeholder bit. Address 3FF is followed by 000.
- R5: A control instruction whose two top address bits are 11 sets the write-enable latch, and one with 00 clears it. A WRITE received while the latch is clear leaves memory unchanged. READ works whatever the state of the latch.
- R6: A WRITE carries 16 data bits, MSB first. Programming starts when chip select falls after the 16th data bit. If another serial clock rise arrives before that fall, the write is cancelled.
- R7: Programming lasts PROG_CYCLES system clock cycles. During that time, with chip select high, data-out drives 0.
- R8: Once programming ends, data-out drives 1 while chip select is high. This holds until the start marker's 1 bit of the next instruction is sampled, after which data-out is released.
- R9: Data-out is undriven whenever chip select is low, and also whenever no read data or status is being presented.
- R10: A frame cut short by chip select falling changes neither memory nor the latch.
- R11: Any instruction clocked in while programming is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled on clk |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data-out drive enable; 0 models high impedance |

## Verification
The bench builds the block with its default array of 1024 words and 16 bits, and with PROG_CYCLES set to 300. That programming window is longer than one complete control frame, so an enable-clear instruction can be sent entirely while the block is busy and then shown to have had no effect. The window is still short enough to wait out fully between writes. The full 10-bit address makes the real 3FF-to-000 rollover reachable in a single three-word read.

// File: rtl/sereep_slave.sv
module sereep_slave #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int CW    = AW + 2;
  localparam int DEPTH = 1 << AW;
  localparam int NW    = $clog2((CW > DW ? CW : DW) + 1);
  localparam int BCW   = $clog2(DW);
  localparam int PCW   = $clog2(PROG_CYCLES + 1);
  localparam logic [NW-1:0]  CMD_LAST = NW'(CW - 1);
  localparam logic [NW-1:0]  DAT_LAST = NW'(DW - 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(DW - 1);
  localparam logic [PCW-1:0] PROG_INIT = PCW'(PROG_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CMD = 3'd1, S_RD = 3'd2, S_WDAT = 3'd3, S_WEND = 3'd4, S_IGN = 3'd5
  } st_t;

  st_t st;
  logic sk_d, cs_d, seen0, wel, busy, stat, rbit;
  logic [NW-1:0]  cnt;
  logic [CW-1:0]  cmd;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdat, rsh;
  logic [BCW-1:0] bpos;
  logic [PCW-1:0] pcnt;
  logic [DW-1:0]  mem [DEPTH];

  wire          rise     = cs_i & sk_i & ~sk_d;
  wire          cs_fall  = cs_d & ~cs_i;
  wire          prog_go  = cs_fall && (st == S_WEND);
  wire [CW-1:0] cmd_nx   = {cmd[CW-2:0], di_i};
  wire [AW-1:0] addr_nx  = cmd_nx[AW-1:0];
  wire [1:0]    op_nx    = cmd_nx[CW-1:CW-2];
  wire [AW-1:0] addr_inc = addr + 1'b1;
  wire          rd_on    = (st == S_RD);

  assign do_oe_o = cs_i & (rd_on | stat);
  assign do_o    = rd_on ? rbit : ~busy;

  always_ff @(posedge clk) begin
    if (prog_go) mem[addr] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sk_d <= 1'b0;
      cs_d <= 1'b0;
      seen0 <= 1'b0;
      wel <= 1'b0;
      busy <= 1'b0;
      stat <= 1'b0;
      rbit <= 1'b0;
      cnt <= '0;
      cmd <= '0;
      addr <= '0;
      wdat <= '0;
      rsh <= '0;
      bpos <= '0;
      pcnt <= '0;
    end else begin
      sk_d <= sk_i;
      cs_d <= cs_i;
      if (busy) begin
        if (pcnt == '0) busy <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end
      if (!cs_i) begin
        st <= S_IDLE;
        seen0 <= 1'b0;
        if (prog_go) begin
          busy <= 1'b1;
          pcnt <= PROG_INIT;
          stat <= 1'b1;
        end
      end else if (rise && !busy) begin
        unique case (st)
          S_IDLE: begin
            if (!di_i) seen0 <= 1'b1;
            else if (seen0) begin
              st <= S_CMD;
              cnt <= '0;
              stat <= 1'b0;
            end
          end
          S_CMD: begin
            cmd <= cmd_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              addr <= addr_nx;
              unique case (op_nx)
                2'b10: begin
                  st <= S_RD;
                  rsh <= mem[addr_nx];
                  rbit <= 1'b0;
                  bpos <= '0;
                end
                2'b01: st <= wel ? S_WDAT : S_IGN;
                2'b00: begin
                  if (addr_nx[AW-1:AW-2] == 2'b11) wel <= 1'b1;
                  else if (addr_nx[AW-1:AW-2] == 2'b00) wel <= 1'b0;
                  st <= S_IGN;
                end
                default: st <= S_IGN;
              endcase
            end
          end
          S_RD: begin
            rbit <= rsh[DW-1];
            if (bpos == BIT_LAST) begin
              bpos <= '0;
              addr <= addr_inc;
              rsh <= mem[addr_inc];
            end else begin
              bpos <= bpos + 1'b1;
              rsh <= {rsh[DW-2:0], 1'b0};
            end
          end
          S_WDAT: begin
            wdat <= {wdat[DW-2:0], di_i};
            cnt <= cnt + 1'b1;
            if (cnt == DAT_LAST) st <= S_WEND;
          end
          S_WEND: st <= S_IGN;
          default: st <= S_IGN;
        endcase
      end
    end
  end
endmodule

// File: rtl/sereep_slave_chk.sv
module sereep_slave_chk #(
  parameter int PCW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           do_o,
  input logic           do_oe_o,
  input logic           busy,
  input logic           wel,
  input logic           rd_on,
  input logic [2:0]     st,
  input logic [PCW-1:0] pcnt
);
  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel); // R5
  AST_BUSY_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe_o) |-> !do_o); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pcnt != '0) |=> busy); // R7
  AST_WEL_AT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wel != $past(wel)) |-> ($past(st) == 3'd1)); // R5
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_on |-> !busy); // R11
endmodule

bind sereep_slave sereep_slave_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .do_o(do_o), .do_oe_o(do_oe_o), .busy(busy),
  .wel(wel), .rd_on(rd_on), .st(st), .pcnt(pcnt)
);

// File: tb/sereep_slave_test.sv
module sereep_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doe;

  sereep_slave #(.AW(10), .DW(16), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_oe_o(doe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic v; logic oe; string tag; } exp_t;
  exp_t q[$];
  event smp;
  int total = 0, bad = 0;
  logic [15:0] model [int];
  bit done = 0;

  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (doe !== e.oe || (e.oe && dout !== e.v)) begin
        bad++;
        $display("FAIL %s: got oe=%b do=%b expected oe=%b do=%b", e.tag, doe, dout, e.oe, e.v);
      end
    end
  end

  task automatic expect_do(input logic v, input logic oe, input string tag);
    exp_t e;
    e.v = v; e.oe = oe; e.tag = tag;
    q.push_back(e);
    -> smp;
    #1;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    di = b; waitn(2);
    sk = 1'b1; waitn(3);
    sk = 1'b0; waitn(2);
  endtask

  task automatic sel();   cs = 1'b1; waitn(2); endtask
  task automatic desel(); cs = 1'b0; di = 1'b0; waitn(3); endtask

  task automatic hdr(input int zeros, input logic [1:0] op, input logic [9:0] a);
    for (int i = 0; i < zeros; i++) clk_bit(1'b0);
    clk_bit(1'b0); clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = 9; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic ctrl(input logic en);
    sel(); hdr(0, 2'b00, en ? 10'h300 : 10'h000); desel();
  endtask

  task automatic write_frame(input logic [9:0] a, input logic [15:0] d);
    sel(); hdr(0, 2'b01, a);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
    desel();
  endtask

  task automatic wait_prog(input string tag);
    sel();
    expect_do(1'b0, 1'b1, {tag, " busy R7"});
    waitn(PROG + 10);
    expect_do(1'b1, 1'b1, "R8 ready");
    desel();
  endtask

  task automatic read_words(input logic [9:0] a, input int n, input string tag);
    sel(); hdr(0, 2'b10, a);
    expect_do(1'b0, 1'b1, "R3 dummy bit");
    for (int w = 0; w < n; w++) begin
      logic [15:0] ev;
      logic [9:0] aa;
      aa = a + 10'(w);
      ev = model.exists(int'(aa)) ? model[int'(aa)] : 16'h0;
      for (int i = 15; i >= 0; i--) begin
        clk_bit(1'b0);
        expect_do(ev[i], 1'b1, tag);
      end
    end
    desel();
    expect_do(1'b0, 1'b0, "R9 released after deselect");
  endtask

  initial begin
    waitn(4);
    expect_do(1'b0, 1'b0, "R9 reset undriven");
    rst_n = 1'b1; waitn(3);

    write_frame(10'h006, 16'hAAAA);
    sel(); expect_do(1'b0, 1'b0, "R1 locked write no status"); desel();

    sel(); hdr(2, 2'b00, 10'h3A5); desel();
    write_frame(10'h005, 16'h1234); model[5] = 16'h1234;
    wait_prog("R2 R6 leading zeros enable");
    sel();
    clk_bit(1'b0); expect_do(1'b1, 1'b1, "R8 status held over zero");
    clk_bit(1'b1); expect_do(1'b0, 1'b0, "R8 released at start bit");
    desel();

    write_frame(10'h3FF, 16'hBEEF); model[10'h3FF] = 16'hBEEF; wait_prog("R6");
    write_frame(10'h000, 16'h0F0F); model[0] = 16'h0F0F; wait_prog("R6");
    write_frame(10'h001, 16'hC3A5); model[1] = 16'hC3A5; wait_prog("R6");

    read_words(10'h005, 1, "R3 single word");
    read_words(10'h3FF, 3, "R4 wrap sequential");

    sel(); hdr(0, 2'b01, 10'h005);
    for (int i = 0; i < 10; i++) clk_bit(1'b1);
    desel();
    sel(); expect_do(1'b0, 1'b0, "R10 aborted write no status"); desel();
    read_words(10'h005, 1, "R10 memory kept");

    sel(); hdr(0, 2'b01, 10'h005);
    for (int i = 0; i < 17; i++) clk_bit(1'b0);
    desel();
    sel(); expect_do(1'b0, 1'b0, "R6 extra rise cancels"); desel();
    read_words(10'h005, 1, "R6 memory kept");

    write_frame(10'h006, 16'h5A5A); model[6] = 16'h5A5A;
    sel(); hdr(0, 2'b00, 10'h000); expect_do(1'b0, 1'b1, "R11 busy during frame"); desel();
    waitn(PROG + 10);
    write_frame(10'h007, 16'h7777); model[7] = 16'h7777;
    wait_prog("R11 latch survived");
    read_words(10'h006, 2, "R11 words stored");

    ctrl(1'b0);
    write_frame(10'h005, 16'hFFFF);
    sel(); expect_do(1'b0, 1'b0, "R5 disabled write no status"); desel();
    read_words(10'h005, 1, "R5 read after disable");

    waitn(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule